// File: doc/BRIEF.md
# Addressed Frame Protocol Controller

This block sits above a byte-stuffing frame decoder on a shared serial bus with many nodes. The decoder streams each frame's decoded payload bytes in, then marks the end of the frame with a pulse and the payload length. The controller uses the length alone to decide what kind of packet arrived:

- A zero-length frame is a discovery probe.
- A four-byte frame carries a node identifier.
- A one-byte frame is a command.
- A frame exactly as long as the frame buffer carries pixel data.

A two-state machine (listening / ignoring) makes sure that only the node whose identifier matched acts on the command or frame data that follows. Any non-discovery packet sends the machine back to ignoring.

The controller's outputs are single-cycle requests: an identity reply (only allowed in a short window after reset), a status reply, and a frame-buffer handoff. A pending flag stays high until the consumer acknowledges the handoff. Three saturating counters record receiver overruns, frame handoffs that arrived while the previous one was still pending, and malformed or unexpected frames. The reply transmitter and the frame storage belong to the surrounding design.

Top module: `addr_frame_ctrl`

## Requirements
- R1: After reset the node is ignoring (`addressed`=0), `fb_pending` is 0, all three counters are 0 and no request output is high.
- R2: A frame with `rx_len`=0 raises `id_req` for one cycle, the cycle after `rx_end`, provided fewer than WINDOW_MS milliseconds (WINDOW_MS×TICKS_PER_MS clock cycles) have passed since reset; later probes raise nothing. The listening state is left unchanged.
- R3: A frame with `rx_len`=4 is compared with DEVICE_ID. Payload byte k (k=0..3) is compared with DEVICE_ID bits [8k+7:8k]. A match sets `addressed`=1; a mismatch sets `addressed`=0.
- R4: A one-byte frame while listening returns the node to ignoring. When the byte is 0x01, it also pulses `status_req` the cycle after `rx_end`; any other byte value requests nothing and counts nothing.
- R5: A one-byte frame while ignoring pulses nothing and adds one to `cnt_invalid`.
- R6: A frame with `rx_len`=FB_BYTES while listening, with no handoff pending, sets `fb_pending`, pulses `fb_ready` and returns the node to ignoring. While ignoring, such a frame changes nothing.
- R7: A frame-buffer frame while listening with `fb_pending` already 1 adds one to `cnt_frame_ovr`, gives no `fb_ready` pulse and leaves `fb_pending` set. `fb_ack` clears `fb_pending`; an `fb_ack` in the same cycle as `rx_end` is applied first.
- R8: A frame of any length other than 0, 1, 4 or FB_BYTES adds one to `cnt_invalid` and forces ignoring.
- R9: Each cycle with `uart_ovr`=1 adds one to `cnt_uart_ovr`.
- R10: Every counter steps by exactly one and holds at all ones instead of wrapping.
- R11: At most one of `id_req`, `status_req`, `fb_ready` is high in any cycle, and each is high for a single cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A decoded payload byte is present |
| rx_byte | input | 8 | Decoded payload byte |
| rx_end | input | 1 | Frame complete (never together with rx_valid) |
| rx_len | input | LEN_W | Payload length of the completed frame |
| uart_ovr | input | 1 | Receiver overrun event |
| fb_ack | input | 1 | Consumer has taken the frame buffer |
| addressed | output | 1 | Node is listening |
| id_req | output | 1 | Send identity reply |
| status_req | output | 1 | Send status reply |
| fb_ready | output | 1 | New frame buffer handed off |
| fb_pending | output | 1 | Frame buffer awaiting acknowledge |
| cnt_uart_ovr | output | CNT_W | Receiver overrun count |
| cnt_frame_ovr | output | CNT_W | Frame overrun count |
| cnt_invalid | output | CNT_W | Invalid frame count |

## Verification
The bench builds the block with 3-bit counters, FB_BYTES=8, TICKS_PER_MS=4 and WINDOW_MS=5. With these values every counter saturates after seven events, and the discovery window closes 20 cycles after reset, so both the open-window and closed-window discovery cases happen within a short run. A frame-buffer length of eight bytes keeps pixel frames short, so the bench can repeat overrun sequences until `cnt_frame_ovr` reaches its ceiling. DEVICE_ID is set to an asymmetric value, which means a byte-order mistake in the identifier comparison shows up as a failed match.

// File: rtl/frmctl_pkg.sv
package frmctl_pkg;

  typedef enum logic [2:0] {
    KIND_DISC = 3'd0,
    KIND_CMD  = 3'd1,
    KIND_ADDR = 3'd2,
    KIND_FB   = 3'd3,
    KIND_BAD  = 3'd4
  } frm_kind_e;

  typedef enum logic {
    ST_IGNORE    = 1'b0,
    ST_ADDRESSED = 1'b1
  } node_state_e;

  localparam logic [7:0] CMD_STATUS = 8'h01;
  localparam int unsigned ID_BYTES  = 4;

  // Packet type comes from the payload length alone.
  function automatic frm_kind_e classify(input int unsigned len, input int unsigned fb_bytes);
    if (len == 0)             return KIND_DISC;
    else if (len == 1)        return KIND_CMD;
    else if (len == ID_BYTES) return KIND_ADDR;
    else if (len == fb_bytes) return KIND_FB;
    else                      return KIND_BAD;
  endfunction

endpackage

// File: rtl/frmctl_capture.sv
module frmctl_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  output logic [31:0] head_word
);
  import frmctl_pkg::*;

  localparam int IDX_W = $clog2(ID_BYTES + 1);

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      word_q;

  // Keeps the first four bytes of each frame, byte 0 in the low lane.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
    end else if (rx_end) begin
      idx_q <= '0;
    end else if (rx_valid && (idx_q < IDX_W'(ID_BYTES))) begin
      word_q[idx_q[1:0]*8 +: 8] <= rx_byte;
      idx_q                     <= idx_q + IDX_W'(1);
    end
  end

  assign head_word = word_q;
endmodule

// File: rtl/frmctl_window.sv
module frmctl_window #(
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned WINDOW_MS    = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open
);
  localparam int PS_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MS_W = $clog2(WINDOW_MS + 1);

  logic [PS_W-1:0] ps_q;
  logic [MS_W-1:0] ms_q;
  logic            ms_tick;

  assign ms_tick = (ps_q == PS_W'(TICKS_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q <= '0;
      ms_q <= '0;
    end else if (ms_q != MS_W'(WINDOW_MS)) begin
      ps_q <= ms_tick ? '0 : ps_q + PS_W'(1);
      if (ms_tick) ms_q <= ms_q + MS_W'(1);
    end
  end

  assign win_open = (ms_q < MS_W'(WINDOW_MS));
endmodule

// File: rtl/frmctl_satcnt.sv
module frmctl_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v);
    return (v == {W{1'b1}}) ? v : v + W'(1);
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= sat_step(cnt_q);
  end

  assign count = cnt_q;
endmodule

// File: rtl/addr_frame_ctrl.sv
module addr_frame_ctrl #(
  parameter logic [31:0] DEVICE_ID    = 32'hDEBE_10BB,
  parameter int unsigned LEN_W        = 8,
  parameter int unsigned FB_BYTES     = 128,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned WINDOW_MS    = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_end,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             uart_ovr,
  input  logic             fb_ack,
  output logic             addressed,
  output logic             id_req,
  output logic             status_req,
  output logic             fb_ready,
  output logic             fb_pending,
  output logic [CNT_W-1:0] cnt_uart_ovr,
  output logic [CNT_W-1:0] cnt_frame_ovr,
  output logic [CNT_W-1:0] cnt_invalid
);
  import frmctl_pkg::*;

  localparam int N_CNT = 3;

  logic [31:0] head_word;
  logic        win_open;
  frm_kind_e   kind;
  node_state_e st_q, st_d;
  logic        pend_q, pend_eff;
  logic        id_q, stat_q, fbr_q;

  // Named frame events
  logic ev_disc, ev_addr_hit, ev_cmd_ok, ev_cmd_bad, ev_fb, ev_fb_take, ev_fb_ovr, ev_bad;

  frmctl_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_end   (rx_end),
    .head_word(head_word)
  );

  frmctl_window #(.TICKS_PER_MS(TICKS_PER_MS), .WINDOW_MS(WINDOW_MS)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_open(win_open)
  );

  assign kind = classify(int'(rx_len), FB_BYTES);

  always_comb begin
    ev_disc     = rx_end && (kind == KIND_DISC);
    ev_addr_hit = rx_end && (kind == KIND_ADDR) && (head_word == DEVICE_ID);
    ev_cmd_ok   = rx_end && (kind == KIND_CMD) && (st_q == ST_ADDRESSED);
    ev_cmd_bad  = rx_end && (kind == KIND_CMD) && (st_q == ST_IGNORE);
    ev_fb       = rx_end && (kind == KIND_FB) && (st_q == ST_ADDRESSED);
    ev_bad      = rx_end && (kind == KIND_BAD);
    pend_eff    = pend_q && !fb_ack;
    ev_fb_take  = ev_fb && !pend_eff;
    ev_fb_ovr   = ev_fb && pend_eff;
  end

  always_comb begin
    st_d = st_q;
    if (rx_end) begin
      case (kind)
        KIND_DISC: st_d = st_q;
        KIND_ADDR: st_d = ev_addr_hit ? ST_ADDRESSED : ST_IGNORE;
        default:   st_d = ST_IGNORE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IGNORE;
      pend_q <= 1'b0;
      id_q   <= 1'b0;
      stat_q <= 1'b0;
      fbr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_eff || ev_fb_take;
      id_q   <= ev_disc && win_open;
      stat_q <= ev_cmd_ok && (head_word[7:0] == CMD_STATUS);
      fbr_q  <= ev_fb_take;
    end
  end

  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  assign cnt_inc = {ev_cmd_bad || ev_bad, ev_fb_ovr, uart_ovr};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    frmctl_satcnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc[g]),
      .count(cnt_val[g])
    );
  end

  assign cnt_uart_ovr  = cnt_val[0];
  assign cnt_frame_ovr = cnt_val[1];
  assign cnt_invalid   = cnt_val[2];
  assign addressed     = (st_q == ST_ADDRESSED);
  assign id_req        = id_q;
  assign status_req    = stat_q;
  assign fb_ready      = fbr_q;
  assign fb_pending    = pend_q;
endmodule

// File: rtl/frmctl_chk.sv
module frmctl_chk #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_end,
  input logic [LEN_W-1:0] rx_len,
  input logic             addressed,
  input logic             id_req,
  input logic             status_req,
  input logic             fb_ready,
  input logic             fb_pending,
  input logic [CNT_W-1:0] cnt_uart_ovr,
  input logic [CNT_W-1:0] cnt_frame_ovr,
  input logic [CNT_W-1:0] cnt_invalid
);
  p_id_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_req |-> ($past(rx_end) && ($past(rx_len) == LEN_W'(0))));

  p_addr_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> ($past(rx_end) && ($past(rx_len) == LEN_W'(4))));

  p_status_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_req |-> ($past(addressed) && $past(rx_end) && ($past(rx_len) == LEN_W'(1)) && !addressed));

  p_fb_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_ready |-> (fb_pending && $past(addressed) && !addressed));

  p_fovr_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_frame_ovr) |-> $past(fb_pending));

  p_inv_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_invalid) |-> (cnt_invalid == $past(cnt_invalid) + CNT_W'(1)));

  p_uart_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_uart_ovr) == {CNT_W{1'b1}}) |-> (cnt_uart_ovr == {CNT_W{1'b1}}));

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({id_req, status_req, fb_ready}));
endmodule

bind addr_frame_ctrl frmctl_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_end       (rx_end),
  .rx_len       (rx_len),
  .addressed    (addressed),
  .id_req       (id_req),
  .status_req   (status_req),
  .fb_ready     (fb_ready),
  .fb_pending   (fb_pending),
  .cnt_uart_ovr (cnt_uart_ovr),
  .cnt_frame_ovr(cnt_frame_ovr),
  .cnt_invalid  (cnt_invalid)
);

// File: tb/test_addr_frame_ctrl.sv
`timescale 1ns/1ps
module test_addr_frame_ctrl;
  localparam logic [31:0] ID = 32'hA5C3_1E07;
  localparam int LEN_W = 8;
  localparam int CNT_W = 3;
  localparam int FB    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_byte = '0;
  logic             rx_end = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic             uart_ovr = 1'b0;
  logic             fb_ack = 1'b0;
  logic             addressed, id_req, status_req, fb_ready, fb_pending;
  logic [CNT_W-1:0] cnt_uart_ovr, cnt_frame_ovr, cnt_invalid;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  addr_frame_ctrl #(
    .DEVICE_ID(ID), .LEN_W(LEN_W), .FB_BYTES(FB), .CNT_W(CNT_W),
    .TICKS_PER_MS(4), .WINDOW_MS(5)
  ) i_addr_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_len(rx_len), .uart_ovr(uart_ovr), .fb_ack(fb_ack),
    .addressed(addressed), .id_req(id_req), .status_req(status_req),
    .fb_ready(fb_ready), .fb_pending(fb_pending), .cnt_uart_ovr(cnt_uart_ovr),
    .cnt_frame_ovr(cnt_frame_ovr), .cnt_invalid(cnt_invalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Streams len bytes (byte k = data[8k+:8]), then ends the frame; returns at the
  // negedge after the registering edge, where the pulses are visible.
  task automatic send_frame(input int len, input logic [63:0] data, input logic ack);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = data[k*8 +: 8];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_end   = 1'b1;
    rx_len   = LEN_W'(len);
    fb_ack   = ack;
    @(negedge clk);
    rx_end = 1'b0;
    fb_ack = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]  len;
    logic [63:0] data;
    logic        ack;
    logic        e_id, e_stat, e_fb, e_pend, e_addr;
    logic [2:0]  e_inv, e_fovr;
  } vec_t;

  localparam logic [63:0] IDW = {32'h0, ID};
  localparam logic [63:0] BAD = {32'h0, ID ^ 32'h0000_0001};
  localparam logic [63:0] PIX = 64'h1122_3344_5566_7788;

  localparam vec_t VEC [18] = '{
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0}, // R3 match
    '{8'd1, 64'h01,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R4 status
    '{8'd1, 64'h01,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0}, // R5 cmd while ignoring
    '{8'd4, BAD,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0}, // R3 mismatch
    '{8'd8, PIX,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0}, // R6 ignored
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0},
    '{8'd8, PIX,      1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 3'd0}, // R6 handoff
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd0},
    '{8'd8, PIX,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1}, // R7 overrun
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
    '{8'd1, 64'h02,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1}, // R4 other cmd
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
    '{8'd3, 64'h0A0B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 3'd1}, // R8 bad length
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd1},
    '{8'd8, PIX,      1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 3'd1}, // R7 ack first
    '{8'd4, IDW,      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd1},
    '{8'd0, 64'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd1}, // R2 window closed, state kept
    '{8'd1, 64'h01,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 3'd1}  // R4 still listening
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addressed", 32'(addressed), 0);
    check("R1 pending", 32'(fb_pending), 0);
    check("R1 counters", {cnt_uart_ovr, cnt_frame_ovr, cnt_invalid}, 0);
    check("R1 requests", {id_req, status_req, fb_ready}, 0);
    rst_n = 1'b1;

    // R2 discovery inside the window
    send_frame(0, 64'h0, 1'b0);
    check("R2 id_req open window", 32'(id_req), 1);
    check("R2 state unchanged", 32'(addressed), 0);
    @(negedge clk);
    check("R11 single-cycle id_req", 32'(id_req), 0);

    foreach (VEC[i]) begin
      send_frame(int'(VEC[i].len), VEC[i].data, VEC[i].ack);
      check($sformatf("R2 id v%0d", i), 32'(id_req), 32'(VEC[i].e_id));
      check($sformatf("R4 status v%0d", i), 32'(status_req), 32'(VEC[i].e_stat));
      check($sformatf("R6 fb_ready v%0d", i), 32'(fb_ready), 32'(VEC[i].e_fb));
      check($sformatf("R7 pending v%0d", i), 32'(fb_pending), 32'(VEC[i].e_pend));
      check($sformatf("R3 addressed v%0d", i), 32'(addressed), 32'(VEC[i].e_addr));
      check($sformatf("R8 invalid v%0d", i), 32'(cnt_invalid), 32'(VEC[i].e_inv));
      check($sformatf("R7 frame_ovr v%0d", i), 32'(cnt_frame_ovr), 32'(VEC[i].e_fovr));
    end
    @(negedge clk);
    check("R11 pulses dropped", {id_req, status_req, fb_ready}, 0);

    // R10 invalid counter saturates: 2 + 6 events -> 7
    for (int k = 0; k < 6; k++) send_frame(2, 64'h0303, 1'b0);
    check("R10 invalid saturates", 32'(cnt_invalid), 7);

    // R10 frame overrun saturates: pending still set, 1 + 7 events -> 7
    for (int k = 0; k < 7; k++) begin
      send_frame(4, IDW, 1'b0);
      send_frame(FB, PIX, 1'b0);
    end
    check("R10 frame_ovr saturates", 32'(cnt_frame_ovr), 7);
    check("R7 pending held", 32'(fb_pending), 1);

    // R7 standalone acknowledge
    @(negedge clk); fb_ack = 1'b1;
    @(negedge clk); fb_ack = 1'b0;
    check("R7 ack clears", 32'(fb_pending), 0);

    // R9 overrun counting and R10 saturation
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); uart_ovr = 1'b1;
      @(negedge clk); uart_ovr = 1'b0;
    end
    check("R9 uart count", 32'(cnt_uart_ovr), 3);
    @(negedge clk); uart_ovr = 1'b1;
    repeat (6) @(negedge clk);
    uart_ovr = 1'b0;
    check("R10 uart saturates", 32'(cnt_uart_ovr), 7);

    done = 1'b1;
  end

  initial begin : watchdog
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule